// File: doc/BRIEF.md
# Four-Channel PWM Controller with Buffered Updates

This block is a memory-mapped pulse-width modulator with four independent outputs. Software reaches it over a plain register bus: a write strobe, a read strobe, a 12-bit byte address and 32-bit data. Reads are combinational, so `rdata_o` is valid in the same cycle as `rd_en_i`. Three global registers start channels, stop channels and report which channels are running. The start and stop registers act on a per-channel write-one bitmask.

Each channel holds a mode word, which selects a power-of-two clock divider and an output polarity. It also holds a live duty value and a live period value, each with its own update buffer. A stopped channel takes every write at once. A running channel ignores writes to the live registers. Values written to its buffers are loaded at the next period boundary, so no period is ever cut short and no glitch appears on the pin. A channel counts from 0 to period-1 on each divided tick. Before polarity is applied, its output is high while the count is below the duty value.

Top module: `pwm_quad`

## Requirements
- R1: After reset, no channel runs, status reads 0, every channel register reads 0 and `pwm_o` is all zero.
- R2: A write to address 0x004 starts each channel n whose data bit n is 1. Zero bits and bits above 3 leave the running set unchanged.
- R3: A write to address 0x008 stops each channel n whose data bit n is 1, and zero bits change nothing. A read of address 0x00C returns the running set in bits [3:0], with every other bit zero.
- R4: Channel n occupies 0x200 + 0x20*n. Its registers sit at these offsets: mode 0x00, live duty 0x04, duty buffer 0x08, live period 0x0C, period buffer 0x10. The mode register reads back the divider select in bits [3:0] and the polarity in bit 9. Duty and period registers read back their low 16 bits. All other bits, unmapped addresses and any cycle with `rd_en_i` low read as 0.
- R5: A shared 10-bit divider counter is 0 after reset and increments every clock. A channel whose select is k advances on the cycles where the low k bits of that counter are all ones (k=0 means every cycle). Select values 11 to 15 act as 10.
- R6: A running channel counts 0,1,...,period-1 on its ticks and then returns to 0. With a period of 0 or 1 the count stays at 0. A stopped channel's count is 0 from the cycle after it stops.
- R7: `pwm_o[n]` equals the polarity bit XOR (running and count < live duty). A stopped channel therefore drives its polarity bit.
- R8: While a channel is stopped, a write to its live duty, live period or either buffer sets the addressed live value from the next cycle on. A buffer write also loads the buffer.
- R9: While a channel runs, writes to its live duty and live period addresses are ignored.
- R10: While a channel runs, a buffer write stores the value, which reads back at once. The value is copied into the live register on the tick where the count returns to 0. A buffer write in that same cycle waits for the following boundary.
- R11: Stopping a channel discards any buffered value not yet applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| pwm_o | output | 4 | Channel outputs |

## Verification
Some properties hold on every cycle, and the assertions check those. The start and stop bitmask writes set and clear only the addressed bits, and the running set changes through nothing else. A stopped channel has a zero count and drives its polarity level. A count never reaches its period. A running channel's live duty changes only on the cycle its count returns to 0. Other behaviour only the bench scenarios can show: the exact high and low run lengths for each divider, including a clamped select, and the staged duty and period updates landing one boundary later. They also show that a buffered value is lost when the channel stops and that writes to live registers are ignored while the channel runs. A cycle-level model runs under random register traffic and checks read data and every output pin.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  localparam int unsigned NCH      = 4;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned PRES_W   = 4;
  localparam int unsigned PRES_MAX = 10;
  localparam int unsigned DW       = 32;
  localparam int unsigned AW       = 12;
  localparam int unsigned POL_BIT  = 9;

  localparam logic [AW-1:0] A_ENA  = 12'h004;
  localparam logic [AW-1:0] A_DIS  = 12'h008;
  localparam logic [AW-1:0] A_STAT = 12'h00C;
  localparam logic [3:0]    CH_REGION = 4'h2;

  localparam logic [4:0] OFF_MODE = 5'h00;
  localparam logic [4:0] OFF_DUTY = 5'h04;
  localparam logic [4:0] OFF_DUPD = 5'h08;
  localparam logic [4:0] OFF_PRD  = 5'h0C;
  localparam logic [4:0] OFF_PUPD = 5'h10;
endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
  parameter int unsigned PRES_MAX = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [PRES_MAX:0] ticks_o
);
  localparam logic [PRES_MAX-1:0] ONE = {{(PRES_MAX-1){1'b0}}, 1'b1};

  logic [PRES_MAX-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + ONE;
  end

  // tick k fires once every 2^k cycles
  assign ticks_o[0] = 1'b1;
  for (genvar k = 1; k <= PRES_MAX; k++) begin : g_tick
    assign ticks_o[k] = &div_q[k-1:0];
  end
endmodule

// File: rtl/pwm_dbuf.sv
`timescale 1ns/1ps
module pwm_dbuf #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         wr_live_i,
  input  logic         wr_upd_i,
  input  logic         apply_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] live_o,
  output logic [W-1:0] upd_o
);
  logic [W-1:0] live_q, upd_q;
  logic         pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      upd_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_upd_i) upd_q <= d_i;
      if (!run_i) begin
        pend_q <= 1'b0;
        if (wr_live_i || wr_upd_i) live_q <= d_i;
      end else begin
        if (apply_i && pend_q) live_q <= upd_q;
        if (wr_upd_i)          pend_q <= 1'b1;
        else if (apply_i)      pend_q <= 1'b0;
      end
    end
  end

  assign live_o = live_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PRES_W   = 4,
  parameter int unsigned PRES_MAX = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [PRES_MAX:0] ticks_i,
  input  logic              wr_i,
  input  logic [4:0]        off_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [PRES_W-1:0] pres_o,
  output logic              pol_o,
  output logic [CNT_W-1:0]  duty_o,
  output logic [CNT_W-1:0]  dupd_o,
  output logic [CNT_W-1:0]  prd_o,
  output logic [CNT_W-1:0]  pupd_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              pwm_o
);
  import pwm_pkg::*;

  localparam int unsigned SEL_W = $clog2(PRES_MAX + 1);
  localparam logic [CNT_W:0] ONE_X = {{CNT_W{1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [PRES_W-1:0] pres_q;
  logic              pol_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SEL_W-1:0]  sel;
  logic              tick, last, wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pres_q <= '0;
      pol_q  <= 1'b0;
    end else if (wr_i && off_i == OFF_MODE) begin
      pres_q <= wdata_i[PRES_W-1:0];
      pol_q  <= wdata_i[POL_BIT];
    end
  end

  // selects above the largest divider clamp to it
  always_comb begin
    if (pres_q > PRES_W'(PRES_MAX)) sel = SEL_W'(PRES_MAX);
    else                            sel = SEL_W'(pres_q);
  end
  assign tick = ticks_i[sel];

  // widened compare so a zero period wraps every tick
  assign last = ({1'b0, cnt_q} + ONE_X) >= {1'b0, prd_o};
  assign wrap = run_i && tick && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick)   cnt_q <= last ? '0 : cnt_q + ONE;
  end

  pwm_dbuf #(.W(CNT_W)) u_duty (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .wr_live_i(wr_i && off_i == OFF_DUTY),
    .wr_upd_i (wr_i && off_i == OFF_DUPD),
    .apply_i  (wrap),
    .d_i      (wdata_i),
    .live_o   (duty_o),
    .upd_o    (dupd_o)
  );

  pwm_dbuf #(.W(CNT_W)) u_prd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .wr_live_i(wr_i && off_i == OFF_PRD),
    .wr_upd_i (wr_i && off_i == OFF_PUPD),
    .apply_i  (wrap),
    .d_i      (wdata_i),
    .live_o   (prd_o),
    .upd_o    (pupd_o)
  );

  assign pres_o = pres_q;
  assign pol_o  = pol_q;
  assign cnt_o  = cnt_q;
  assign pwm_o  = pol_q ^ (run_i && (cnt_q < duty_o));
endmodule

// File: rtl/pwm_quad.sv
`timescale 1ns/1ps
module pwm_quad #(
  parameter int unsigned NCH      = 4,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PRES_MAX = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic [pwm_pkg::AW-1:0] addr_i,
  input  logic [pwm_pkg::DW-1:0] wdata_i,
  output logic [pwm_pkg::DW-1:0] rdata_o,
  output logic [NCH-1:0]         pwm_o
);
  import pwm_pkg::*;

  logic [NCH-1:0]             run_q;
  logic [PRES_MAX:0]          ticks;
  logic                       in_ch;
  logic [2:0]                 idx;
  logic [4:0]                 off;
  logic [NCH-1:0]             hit_w, pol_w;
  logic [NCH-1:0][PRES_W-1:0] pres_w;
  logic [NCH-1:0][CNT_W-1:0]  duty_w, dupd_w, prd_w, pupd_w, cnt_w;
  logic                       unused_w;

  assign unused_w = ^wdata_i[DW-1:CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           run_q <= '0;
    else if (wr_en_i && addr_i == A_ENA)   run_q <= run_q | wdata_i[NCH-1:0];
    else if (wr_en_i && addr_i == A_DIS)   run_q <= run_q & ~wdata_i[NCH-1:0];
  end

  pwm_prescaler #(.PRES_MAX(PRES_MAX)) u_pres (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ticks_o(ticks)
  );

  assign in_ch = (addr_i[AW-1:8] == CH_REGION);
  assign idx   = addr_i[7:5];
  assign off   = addr_i[4:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign hit_w[c] = in_ch && (idx == 3'(c));

    pwm_channel #(.CNT_W(CNT_W), .PRES_W(PRES_W), .PRES_MAX(PRES_MAX)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_q[c]),
      .ticks_i(ticks),
      .wr_i   (wr_en_i && hit_w[c]),
      .off_i  (off),
      .wdata_i(wdata_i[CNT_W-1:0]),
      .pres_o (pres_w[c]),
      .pol_o  (pol_w[c]),
      .duty_o (duty_w[c]),
      .dupd_o (dupd_w[c]),
      .prd_o  (prd_w[c]),
      .pupd_o (pupd_w[c]),
      .cnt_o  (cnt_w[c]),
      .pwm_o  (pwm_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (addr_i == A_STAT) rdata_o[NCH-1:0] = run_q;
      for (int c = 0; c < NCH; c++) begin
        if (hit_w[c]) begin
          case (off)
            OFF_MODE: begin
              rdata_o[PRES_W-1:0] = pres_w[c];
              rdata_o[POL_BIT]    = pol_w[c];
            end
            OFF_DUTY: rdata_o[CNT_W-1:0] = duty_w[c];
            OFF_DUPD: rdata_o[CNT_W-1:0] = dupd_w[c];
            OFF_PRD:  rdata_o[CNT_W-1:0] = prd_w[c];
            OFF_PUPD: rdata_o[CNT_W-1:0] = pupd_w[c];
            default:  ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pwm_quad_chk.sv
`timescale 1ns/1ps
module pwm_quad_chk #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned CNT_W = 16
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            wr_en_i,
  input logic [pwm_pkg::AW-1:0]          addr_i,
  input logic [NCH-1:0]                  wmask_i,
  input logic [NCH-1:0]                  run_i,
  input logic [NCH-1:0]                  pol_i,
  input logic [NCH-1:0][CNT_W-1:0]       cnt_i,
  input logic [NCH-1:0][CNT_W-1:0]       prd_i,
  input logic [NCH-1:0][CNT_W-1:0]       duty_i,
  input logic [NCH-1:0]                  pwm_i
);
  import pwm_pkg::*;

  assert_ena_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_ENA) |=> ((run_i & $past(wmask_i)) == $past(wmask_i)))
    else $error("start bits not set");

  assert_ena_keeps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_ENA) |=> ((run_i & $past(run_i)) == $past(run_i)))
    else $error("start write stopped a channel");

  assert_dis_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_DIS) |=> ((run_i & $past(wmask_i)) == '0))
    else $error("stop bits not cleared");

  assert_run_only_by_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (addr_i == A_ENA || addr_i == A_DIS)) |=> $stable(run_i))
    else $error("running set changed without a mask write");

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assert_idle_cnt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i[c] |=> (cnt_i[c] == '0))
      else $error("stopped channel count not zero");

    assert_cnt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i[c] < prd_i[c]) || (cnt_i[c] == '0))
      else $error("count reached period");

    assert_idle_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i[c] |-> (pwm_i[c] == pol_i[c]))
      else $error("stopped channel not at idle level");

    assert_duty_at_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i[c] && $past(run_i[c]) && cnt_i[c] != '0) |-> $stable(duty_i[c]))
      else $error("live duty changed mid period");
  end
endmodule

bind pwm_quad pwm_quad_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wmask_i(wdata_i[NCH-1:0]),
  .run_i  (run_q),
  .pol_i  (pol_w),
  .cnt_i  (cnt_w),
  .prd_i  (prd_w),
  .duty_i (duty_w),
  .pwm_i  (pwm_o)
);

// File: tb/tb_pwm_quad.sv
`timescale 1ns/1ps
module tb_pwm_quad;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm;
  int          total = 0, bad = 0;
  bit          mon_on = 1'b0, timeout = 1'b0;

  always #4 clk_i = ~clk_i;

  pwm_quad dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  // cycle-level model built from the requirements
  logic [3:0]  m_run;
  logic [9:0]  m_div;
  logic [3:0]  m_pres [4];
  logic        m_pol  [4];
  logic [15:0] m_duty [4], m_dbuf [4], m_prd [4], m_pbuf [4], m_cnt [4];
  logic        m_dp   [4], m_pp   [4];

  function automatic logic hit(int c, int off);
    return wr_en && (addr == 12'(32'h200 + c*32 + off));
  endfunction
  function automatic logic tk(int c);
    int k = (m_pres[c] > 4'd10) ? 10 : int'(m_pres[c]);
    logic [9:0] mask = 10'((1 << k) - 1);
    return (m_div & mask) == mask;
  endfunction
  function automatic logic wrp(int c);
    return m_run[c] && tk(c) && ((17'(m_cnt[c]) + 17'd1) >= 17'(m_prd[c]));
  endfunction
  function automatic logic exp_pwm(int c);
    return m_pol[c] ^ (m_run[c] && (m_cnt[c] < m_duty[c]));
  endfunction
  function automatic logic [31:0] exp_rd(logic [11:0] a);
    logic [31:0] r = '0;
    int c;
    if (a == 12'h00C) r[3:0] = m_run;
    else if (a[11:8] == 4'h2 && a[7:5] < 3'd4) begin
      c = int'(a[7:5]);
      case (a[4:0])
        5'h00: begin r[3:0] = m_pres[c]; r[9] = m_pol[c]; end
        5'h04: r[15:0] = m_duty[c];
        5'h08: r[15:0] = m_dbuf[c];
        5'h0C: r[15:0] = m_prd[c];
        5'h10: r[15:0] = m_pbuf[c];
        default: ;
      endcase
    end
    return r;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run <= '0;
      m_div <= '0;
      for (int c = 0; c < 4; c++) begin
        m_pres[c] <= '0; m_pol[c] <= 1'b0; m_duty[c] <= '0; m_dbuf[c] <= '0;
        m_prd[c] <= '0; m_pbuf[c] <= '0; m_cnt[c] <= '0; m_dp[c] <= 1'b0; m_pp[c] <= 1'b0;
      end
    end else begin
      m_div <= m_div + 10'd1;
      if (wr_en && addr == 12'h004) m_run <= m_run | wdata[3:0];
      if (wr_en && addr == 12'h008) m_run <= m_run & ~wdata[3:0];
      for (int c = 0; c < 4; c++) begin
        if (hit(c, 0)) begin m_pres[c] <= wdata[3:0]; m_pol[c] <= wdata[9]; end
        if (!m_run[c]) m_cnt[c] <= '0;
        else if (tk(c)) m_cnt[c] <= wrp(c) ? 16'd0 : m_cnt[c] + 16'd1;
        if (hit(c, 8))  m_dbuf[c] <= wdata[15:0];
        if (hit(c, 16)) m_pbuf[c] <= wdata[15:0];
        if (!m_run[c]) begin
          m_dp[c] <= 1'b0;
          m_pp[c] <= 1'b0;
          if (hit(c, 4) || hit(c, 8))   m_duty[c] <= wdata[15:0];
          if (hit(c, 12) || hit(c, 16)) m_prd[c]  <= wdata[15:0];
        end else begin
          if (wrp(c) && m_dp[c]) m_duty[c] <= m_dbuf[c];
          if (wrp(c) && m_pp[c]) m_prd[c]  <= m_pbuf[c];
          if (hit(c, 8))   m_dp[c] <= 1'b1;
          else if (wrp(c)) m_dp[c] <= 1'b0;
          if (hit(c, 16))  m_pp[c] <= 1'b1;
          else if (wrp(c)) m_pp[c] <= 1'b0;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // every output pin checked against the model on every cycle
  always @(negedge clk_i) begin
    if (mon_on && rst_ni)
      for (int c = 0; c < 4; c++) chk("R7 pin vs model", 32'(pwm[c]), 32'(exp_pwm(c)));
  end

  function automatic logic [11:0] ca(int c, int off);
    return 12'(32'h200 + c*32 + off);
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk_i); wr_en = 1'b0;
  endtask
  task automatic rd(logic [11:0] a, string tag, logic [31:0] exp);
    @(negedge clk_i); rd_en = 1'b1; addr = a; #1;
    chk(tag, rdata, exp);
    rd_en = 1'b0;
  endtask
  task automatic rd_model(logic [11:0] a);
    @(negedge clk_i); rd_en = 1'b1; addr = a; #1;
    chk("R4 read vs model", rdata, exp_rd(a));
    rd_en = 1'b0;
  endtask
  task automatic wait_rise(int c);
    logic prev;
    @(negedge clk_i); #1; prev = pwm[c];
    forever begin
      @(negedge clk_i); #1;
      if (pwm[c] && !prev) break;
      prev = pwm[c];
    end
  endtask
  task automatic run_len(int c, logic lvl, output int n);
    n = 0;
    while (pwm[c] == lvl) begin n++; @(negedge clk_i); #1; end
  endtask
  task automatic count_high(int c, int n, output int h);
    h = 0;
    repeat (n) begin @(negedge clk_i); #1; h += int'(pwm[c]); end
  endtask

  task automatic directed();
    int h;
    // R1 reset state
    rd(12'h00C, "R1 status after reset", 32'h0);
    rd(ca(0, 0), "R1 mode after reset", 32'h0);
    rd(ca(3, 4), "R1 duty after reset", 32'h0);
    chk("R1 pins after reset", 32'(pwm), 32'h0);
    // R4 map and widths
    wr(ca(1, 0), 32'hFFFF_FFFF);
    rd(ca(1, 0), "R4 mode readback fields", 32'h0000_020F);
    wr(ca(1, 0), 32'h0);
    rd(12'h100, "R4 unmapped read", 32'h0);
    rd(12'h280, "R4 beyond last channel", 32'h0);
    @(negedge clk_i); addr = ca(1, 0); #1;
    chk("R4 no read strobe", rdata, 32'h0);
    // R8 direct loads while stopped
    wr(ca(2, 4), 32'h1234_ABCD);
    rd(ca(2, 4), "R8 duty direct, upper zero", 32'h0000_ABCD);
    wr(ca(3, 12), 32'hFFFF_0010);
    rd(ca(3, 12), "R8 period direct", 32'h10);
    wr(ca(3, 16), 32'hDEAD_0022);
    rd(ca(3, 16), "R8 period buffer", 32'h22);
    rd(ca(3, 12), "R8 buffer write loads live when stopped", 32'h22);
    // R2 / R3 bitmasks
    wr(12'h004, 32'h5);  rd(12'h00C, "R2 start 0101", 32'h5);
    wr(12'h004, 32'h0);  rd(12'h00C, "R2 zero mask no effect", 32'h5);
    wr(12'h004, 32'h2);  rd(12'h00C, "R2 add ch1", 32'h7);
    wr(12'h008, 32'h1);  rd(12'h00C, "R3 stop ch0", 32'h6);
    wr(12'h008, 32'h0);  rd(12'h00C, "R3 zero mask no effect", 32'h6);
    wr(12'h008, 32'hFFFF_FFFF); rd(12'h00C, "R3 stop all", 32'h0);
    wr(12'h004, 32'hFFFF_FFF0); rd(12'h00C, "R2 upper bits ignored", 32'h0);
    // R7 idle level
    wr(ca(0, 0), 32'h200); @(negedge clk_i); #1;
    chk("R7 stopped inverted idles high", 32'(pwm[0]), 32'h1);
    wr(ca(0, 0), 32'h0); @(negedge clk_i); #1;
    chk("R7 stopped normal idles low", 32'(pwm[0]), 32'h0);
    // R6 count sequence, period 4 duty 1 divider 1
    wr(ca(0, 12), 32'd4); wr(ca(0, 4), 32'd1); wr(12'h004, 32'h1);
    repeat (8) @(negedge clk_i);
    count_high(0, 40, h); chk("R6 period 4 duty 1 highs", 32'(h), 32'd10);
    wr(ca(0, 0), 32'h200);
    count_high(0, 40, h); chk("R7 inverted running highs", 32'(h), 32'd30);
    // R9 live writes ignored while running
    wr(ca(0, 4), 32'd3);  rd(ca(0, 4), "R9 live duty ignored", 32'd1);
    wr(ca(0, 12), 32'd9); rd(ca(0, 12), "R9 live period ignored", 32'd4);
    count_high(0, 40, h); chk("R9 waveform unchanged", 32'(h), 32'd30);
    wr(12'h008, 32'h1); wr(ca(0, 0), 32'h0);
    // R5 divider 4
    wr(ca(1, 12), 32'd4); wr(ca(1, 4), 32'd2); wr(ca(1, 0), 32'd2); wr(12'h004, 32'h2);
    wait_rise(1);
    run_len(1, 1'b1, h); chk("R5 divider 4 high run", 32'(h), 32'd8);
    count_high(1, 64, h); chk("R5 divider 4 highs per 64", 32'(h), 32'd32);
    // R5 clamp: select 15 acts as divider 1024
    wr(ca(2, 12), 32'd2); wr(ca(2, 4), 32'd1); wr(ca(2, 0), 32'hF); wr(12'h004, 32'h4);
    wait_rise(2);
    run_len(2, 1'b1, h); chk("R5 select 15 clamps to 10", 32'(h), 32'd1024);
    wr(12'h008, 32'h6);
    // R10 buffered updates
    wr(ca(3, 12), 32'd1000); wr(ca(3, 4), 32'd10); wr(ca(3, 0), 32'h0); wr(12'h004, 32'h8);
    wait_rise(3);
    wr(ca(3, 8), 32'd500);
    rd(ca(3, 4), "R10 live duty held", 32'd10);
    rd(ca(3, 8), "R10 buffer reads back", 32'd500);
    wait_rise(3);
    run_len(3, 1'b1, h); chk("R10 new duty after boundary", 32'(h), 32'd500);
    wr(ca(3, 16), 32'd200); wr(ca(3, 8), 32'd50);
    rd(ca(3, 12), "R10 live period held", 32'd1000);
    wait_rise(3);
    run_len(3, 1'b1, h); chk("R10 duty 50 high run", 32'(h), 32'd50);
    run_len(3, 1'b0, h); chk("R10 period 200 low run", 32'(h), 32'd150);
    // R11 stop discards buffer
    wait_rise(3);
    wr(ca(3, 8), 32'd120); wr(12'h008, 32'h8);
    rd(ca(3, 4), "R11 duty after stop", 32'd50);
    wr(12'h004, 32'h8);
    wait_rise(3); wait_rise(3);
    rd(ca(3, 4), "R11 discarded update not applied", 32'd50);
    wr(12'h008, 32'hF);
  endtask

  task automatic random_phase();
    int offs [6] = '{0, 4, 8, 12, 16, 20};
    for (int i = 0; i < 3000; i++) begin
      int op = int'($urandom % 8);
      int c = int'($urandom % 4);
      int o = offs[$urandom % 5];
      logic [31:0] junk = {$urandom, 16'h0} & 32'hFFFF_0000;
      case (op)
        0: wr(12'h004, $urandom);
        1: wr(12'h008, $urandom);
        2, 3, 4, 5: begin
          if (o == 0)
            wr(ca(c, 0), junk | ((($urandom % 8) == 0) ? 32'd11 : ($urandom % 4)) |
                         (($urandom % 2) << 9));
          else if (o == 4 || o == 8) wr(ca(c, o), junk | ($urandom % 24));
          else                       wr(ca(c, o), junk | ($urandom % 20));
        end
        default: begin
          int s = int'($urandom % 8);
          if (s == 0)      rd_model(12'h00C);
          else if (s == 1) rd_model(12'h004);
          else if (s == 2) rd_model(12'h280);
          else             rd_model(ca(c, offs[$urandom % 6]));
        end
      endcase
      repeat ($urandom % 4) @(negedge clk_i);
    end
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd51977);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    mon_on = 1'b1;
    fork
      begin directed(); random_phase(); end
      begin repeat (150000) @(posedge clk_i); timeout = 1'b1; end
    join_any
    disable fork;
    if (timeout) begin
      total++; bad++;
      $display("FAIL watchdog act=expired exp=completed");
    end
    mon_on = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule